// File: doc/BRIEF.md
# Chainable Free-Slot Write Allocator

This block is the free-location logic of one slice in a chain of content-addressable memory slices. Each slice keeps an occupied bit per entry and a data word per entry. It works out whether it has any room left. It also takes part in an active-low "full" chain. A slice is the chosen allocator when the flag coming in from the slice above says that every higher-priority slice is full, and the slice itself still has a hole. A write-next or read-next cycle broadcast to the whole chain is therefore taken by exactly one slice. Inside that slice, the cycle lands on the lowest-numbered empty entry.

Entries are freed by a broadcast delete that carries a global address: the slice ID in the upper bits and the local index in the lower bits. Later write-next cycles fill the holes lowest-first, across the whole chain, so nothing outside the chain has to track which locations are empty. The outgoing full flag is registered. It therefore ripples down the chain one slice per clock, and allocation cycles must be spaced far enough apart for the chain to settle. The full flag out of the last slice is the system-full indication. The first slice has its incoming flag tied low.

Top module: `nfa_slice`

## Requirements
- R1: After reset no entry is occupied, `fullOut_n` is high, and `nfaValid` and `rdValid` are low.
- R2: `fullOut_n` is low in a cycle only if, in the previous cycle, `fullIn_n` was low and every entry of the slice was occupied.
- R3: If `fullIn_n` was high in the previous cycle, `fullOut_n` is high, whether or not the slice is full.
- R4: A slice responds to a write-next (`cmdOp`=1) or read-next (`cmdOp`=2) cycle only while `fullIn_n` is low and it has a free entry. Across a settled chain exactly one slice responds, and none responds when every entry in the chain is occupied.
- R5: A write-next taken by a slice stores `cmdData` in its lowest-indexed free entry and marks that entry occupied, so the chain fills the lowest global free address.
- R6: A read-next taken by a slice pulses `nfaValid` for one cycle after the command cycle, with `nfaAddr` = {`sliceId`, lowest free local index}. The command changes no occupied bit.
- R7: A delete (`cmdOp`=3) clears the occupied bit of entry `cmdAddr` low bits in the slice whose `sliceId` equals the `cmdAddr` high bits. Other slices ignore it, and a cycle with `cmdValid` low changes no occupied bit.
- R8: A read-entry (`cmdOp`=4) addressed to a slice pulses `rdValid` one cycle later, with `rdHit` = the entry's occupied bit and `rdData` = its stored word.
- R9: The full flag does not change during the write or delete cycle itself. It updates on the clock after the cycle ends, and after a chain of N slices has settled for N cycles, the last `fullOut_n` is low exactly when every entry in the chain is occupied.
- R10: A write-next issued while the whole chain is full changes no entry and no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sliceId | input | ID_W | Position of this slice in the chain |
| fullIn_n | input | 1 | Low when all higher-priority slices are full (tie low on the first slice) |
| fullOut_n | output | 1 | Registered full flag passed to the next slice |
| cmdValid | input | 1 | Command strobe, one cycle per command |
| cmdOp | input | 3 | 0 idle, 1 write-next, 2 read-next, 3 delete, 4 read-entry |
| cmdAddr | input | ID_W+log2(ENTRIES) | Global address {slice ID, local index} for delete and read-entry |
| cmdData | input | DATA_W | Word stored by write-next |
| nfaValid | output | 1 | Read-next response strobe from the responding slice |
| nfaAddr | output | ID_W+log2(ENTRIES) | Global next free address |
| rdValid | output | 1 | Read-entry response strobe |
| rdHit | output | 1 | Addressed entry is occupied |
| rdData | output | DATA_W | Addressed entry's stored word |

## Verification
The hardest state to reach is a chain in which the free locations are scattered: holes in the middle of an earlier slice while later slices are partly full. This is the case where the full chain must hand the next allocation back upstream. The bench first fills all four slices in order. It then deletes entries in a chosen non-contiguous pattern across slices and checks that writes refill them lowest-first. After that, a long random mix of write-next, delete, read-next and read-entry cycles, weighted toward writes, keeps the chain oscillating near full and empty.

// File: rtl/nfa_pkg.sv
package nfa_pkg;

  typedef enum logic [2:0] {
    OP_IDLE       = 3'd0,
    OP_WRITE_NEXT = 3'd1,
    OP_READ_NEXT  = 3'd2,
    OP_DELETE     = 3'd3,
    OP_READ_ENTRY = 3'd4
  } nfaOp_e;

  // Strobes from the control half to the datapath half, at most one per cycle.
  typedef struct packed {
    logic wrNext;
    logic rdNext;
    logic clrAt;
    logic rdAt;
  } nfaStrobe_t;

endpackage

// File: rtl/nfa_ctrl.sv
module nfa_ctrl
  import nfa_pkg::*;
#(
  parameter int ID_W  = 2,
  parameter int IDX_W = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmdValid,
  input  logic [2:0]            cmdOp,
  input  logic [ID_W+IDX_W-1:0] cmdAddr,
  input  logic [ID_W-1:0]       sliceId,
  input  logic                  fullIn_n,
  input  logic                  localFull,
  output nfaStrobe_t            strobe,
  output logic [IDX_W-1:0]      localIdx,
  output logic                  fullOut_n
);

  nfaOp_e op;
  logic   responder;
  logic   addrHit;

  assign op        = nfaOp_e'(cmdOp);
  assign responder = !fullIn_n && !localFull;
  assign addrHit   = (cmdAddr[ID_W+IDX_W-1:IDX_W] == sliceId);
  assign localIdx  = cmdAddr[IDX_W-1:0];

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      unique case (op)
        OP_WRITE_NEXT: strobe.wrNext = responder;
        OP_READ_NEXT:  strobe.rdNext = responder;
        OP_DELETE:     strobe.clrAt  = addrHit;
        OP_READ_ENTRY: strobe.rdAt   = addrHit;
        default:       strobe        = '0;
      endcase
    end
  end

  // The flag is registered: it follows the occupied bits left by the
  // finished cycle and ripples one slice per clock down the chain.
  always_ff @(posedge clk) begin
    if (!rst_n) fullOut_n <= 1'b1;
    else        fullOut_n <= fullIn_n || !localFull;
  end

endmodule

// File: rtl/nfa_datapath.sv
module nfa_datapath
  import nfa_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 16,
  parameter int ID_W    = 2,
  parameter int IDX_W   = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  nfaStrobe_t            strobe,
  input  logic [IDX_W-1:0]      localIdx,
  input  logic [DATA_W-1:0]     cmdData,
  input  logic [ID_W-1:0]       sliceId,
  output logic                  localFull,
  output logic [ENTRIES-1:0]    validVec,
  output logic                  nfaValid,
  output logic [ID_W+IDX_W-1:0] nfaAddr,
  output logic                  rdValid,
  output logic                  rdHit,
  output logic [DATA_W-1:0]     rdData
);

  logic [ENTRIES-1:0][DATA_W-1:0] mem;
  logic [IDX_W-1:0]               freeIdx;
  logic [ENTRIES-1:0]             wrSel;
  logic [ENTRIES-1:0]             clrSel;

  // Lowest-indexed clear bit wins.
  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) freeIdx = IDX_W'(i);
    end
  end

  assign localFull = &validVec;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign wrSel[e]  = strobe.wrNext && (freeIdx == IDX_W'(e));
    assign clrSel[e] = strobe.clrAt && (localIdx == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      validVec <= '0;
      mem      <= '0;
    end else begin
      validVec <= (validVec | wrSel) & ~clrSel;
      for (int e = 0; e < ENTRIES; e++) begin
        if (wrSel[e]) mem[e] <= cmdData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nfaValid <= 1'b0;
      nfaAddr  <= '0;
      rdValid  <= 1'b0;
      rdHit    <= 1'b0;
      rdData   <= '0;
    end else begin
      nfaValid <= strobe.rdNext;
      nfaAddr  <= {sliceId, freeIdx};
      rdValid  <= strobe.rdAt;
      rdHit    <= validVec[localIdx];
      rdData   <= mem[localIdx];
    end
  end

endmodule

// File: rtl/nfa_slice.sv
module nfa_slice
  import nfa_pkg::*;
#(
  parameter int  ENTRIES = 8,
  parameter int  DATA_W  = 16,
  parameter int  ID_W    = 2,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int ADDR_W  = ID_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   sliceId,
  input  logic              fullIn_n,
  output logic              fullOut_n,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              nfaValid,
  output logic [ADDR_W-1:0] nfaAddr,
  output logic              rdValid,
  output logic              rdHit,
  output logic [DATA_W-1:0] rdData
);

  nfaStrobe_t         strobe;
  logic [IDX_W-1:0]   localIdx;
  logic               localFull;
  logic [ENTRIES-1:0] validVec;

  nfa_ctrl #(.ID_W(ID_W), .IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .sliceId(sliceId), .fullIn_n(fullIn_n),
    .localFull(localFull), .strobe(strobe), .localIdx(localIdx),
    .fullOut_n(fullOut_n)
  );

  nfa_datapath #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .ID_W(ID_W), .IDX_W(IDX_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .localIdx(localIdx),
    .cmdData(cmdData), .sliceId(sliceId), .localFull(localFull),
    .validVec(validVec), .nfaValid(nfaValid), .nfaAddr(nfaAddr),
    .rdValid(rdValid), .rdHit(rdHit), .rdData(rdData)
  );

endmodule

// File: rtl/nfa_slice_checker.sv
module nfa_slice_checker #(
  parameter int ENTRIES = 8,
  parameter int ID_W    = 2,
  parameter int IDX_W   = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ID_W-1:0]       sliceId,
  input logic                  fullIn_n,
  input logic                  fullOut_n,
  input logic                  cmdValid,
  input logic [2:0]            cmdOp,
  input logic [ID_W+IDX_W-1:0] cmdAddr,
  input logic                  nfaValid,
  input logic [ID_W+IDX_W-1:0] nfaAddr,
  input logic                  rdValid,
  input logic                  localFull,
  input logic [ENTRIES-1:0]    validVec
);

  assert_reset_empty_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> (validVec == '0 && fullOut_n && !nfaValid && !rdValid));

  assert_full_needs_chain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !fullOut_n |-> $past(!fullIn_n && localFull));

  assert_upstream_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fullIn_n) |-> fullOut_n);

  assert_write_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == 3'd1 && !fullIn_n && !localFull)
      |=> $countones(validVec) == $past($countones(validVec)) + 1);

  assert_non_responder_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == 3'd1 && (fullIn_n || localFull)) |=> $stable(validVec));

  assert_readnext_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nfaValid |-> ($past(cmdValid && cmdOp == 3'd2 && !fullIn_n && !localFull)
                  && nfaAddr[ID_W+IDX_W-1:IDX_W] == sliceId));

  assert_readnext_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdOp == 3'd2) |=> $stable(validVec));

  assert_idle_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> $stable(validVec));

  assert_read_entry_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rdValid |-> $past(cmdValid && cmdOp == 3'd4
                      && cmdAddr[ID_W+IDX_W-1:IDX_W] == sliceId));

endmodule

bind nfa_slice nfa_slice_checker #(.ENTRIES(ENTRIES), .ID_W(ID_W), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .sliceId(sliceId), .fullIn_n(fullIn_n),
  .fullOut_n(fullOut_n), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
  .nfaValid(nfaValid), .nfaAddr(nfaAddr), .rdValid(rdValid),
  .localFull(localFull), .validVec(validVec)
);

// File: tb/nfa_slice_tb_top.sv
module nfa_slice_tb_top;

  localparam int NS      = 4;
  localparam int ENTRIES = 4;
  localparam int DATA_W  = 16;
  localparam int ID_W    = 2;
  localparam int IDX_W   = 2;
  localparam int ADDR_W  = ID_W + IDX_W;
  localparam int TOTAL   = NS * ENTRIES;
  localparam int SETTLE  = NS - 1;   // idle cycles between commands for the chain

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              cmdValid = 1'b0;
  logic [2:0]        cmdOp    = 3'd0;
  logic [ADDR_W-1:0] cmdAddr  = '0;
  logic [DATA_W-1:0] cmdData  = '0;

  logic              fo [NS];
  logic              fi [NS];
  logic              nfaV [NS];
  logic [ADDR_W-1:0] nfaA [NS];
  logic              rdV [NS];
  logic              rdH [NS];
  logic [DATA_W-1:0] rdD [NS];

  assign fi[0] = 1'b0;
  for (genvar g = 0; g < NS; g++) begin : g_chain
    if (g > 0) begin : g_link
      assign fi[g] = fo[g-1];
    end
    if (g == 0) begin : g_dut
      nfa_slice #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .ID_W(ID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sliceId(ID_W'(g)), .fullIn_n(fi[g]),
        .fullOut_n(fo[g]), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
        .cmdData(cmdData), .nfaValid(nfaV[g]), .nfaAddr(nfaA[g]),
        .rdValid(rdV[g]), .rdHit(rdH[g]), .rdData(rdD[g]));
    end else begin : g_other
      nfa_slice #(.ENTRIES(ENTRIES), .DATA_W(DATA_W), .ID_W(ID_W)) slice_i (
        .clk(clk), .rst_n(rst_n), .sliceId(ID_W'(g)), .fullIn_n(fi[g]),
        .fullOut_n(fo[g]), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
        .cmdData(cmdData), .nfaValid(nfaV[g]), .nfaAddr(nfaA[g]),
        .rdValid(rdV[g]), .rdHit(rdH[g]), .rdData(rdD[g]));
    end
  end

  // Reference model
  bit          occ [TOTAL];
  logic [15:0] dat [TOTAL];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Captured response of the last command
  int nvCnt, nvAddr, rvCnt, rvHit, rvData;

  function automatic int lowestFree();
    for (int i = 0; i < TOTAL; i++) if (!occ[i]) return i;
    return -1;
  endfunction

  function automatic int usedCount();
    int c = 0;
    for (int i = 0; i < TOTAL; i++) if (occ[i]) c++;
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [2:0] op, input int addr, input int data);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdAddr  = ADDR_W'(addr);
    cmdData  = DATA_W'(data);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdOp    = 3'd0;
    nvCnt = 0; nvAddr = -1; rvCnt = 0; rvHit = 0; rvData = 0;
    for (int s = 0; s < NS; s++) begin
      if (nfaV[s]) begin nvCnt++; nvAddr = int'(nfaA[s]); end
      if (rdV[s])  begin rvCnt++; rvHit = int'(rdH[s]); rvData = int'(rdD[s]); end
    end
    repeat (SETTLE + 1) @(negedge clk);
  endtask

  task automatic doReadNext();
    int exp = lowestFree();
    issue(3'd2, 0, 0);
    check(nvCnt == (exp < 0 ? 0 : 1), "R4 responder count", nvCnt, exp < 0 ? 0 : 1);
    if (exp >= 0) check(nvAddr == exp, "R6 next free address", nvAddr, exp);
  endtask

  task automatic doWrite(input int data);
    int f = lowestFree();
    issue(3'd1, 0, data);
    if (f >= 0) begin occ[f] = 1'b1; dat[f] = 16'(data); end
    check(int'(!fo[NS-1]) == int'(usedCount() == TOTAL), "R9 system full", int'(!fo[NS-1]),
          int'(usedCount() == TOTAL));
  endtask

  task automatic doDelete(input int a);
    issue(3'd3, a, 0);
    occ[a] = 1'b0;
    check(fo[NS-1] == 1'b1, "R7 system not full after delete", int'(fo[NS-1]), 1);
  endtask

  task automatic doReadEntry(input int a);
    issue(3'd4, a, 0);
    check(rvCnt == 1, "R8 one read response", rvCnt, 1);
    check(rvHit == int'(occ[a]), "R8 occupied bit", rvHit, int'(occ[a]));
    if (occ[a]) check(rvData == int'(dat[a]), "R5 stored data", rvData, int'(dat[a]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < TOTAL; i++) begin occ[i] = 1'b0; dat[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < NS; s++) begin
      check(fo[s] == 1'b1, "R1 fullOut after reset", int'(fo[s]), 1);
      check(!nfaV[s] && !rdV[s], "R1 no strobes after reset", int'(nfaV[s] | rdV[s]), 0);
    end
    doReadEntry(5);

    // R5/R6: fill the chain in order
    for (int i = 0; i < TOTAL; i++) begin
      doReadNext();
      if (i == TOTAL - 1) begin
        // R9: flag does not move in the write cycle itself
        @(negedge clk);
        cmdValid = 1'b1; cmdOp = 3'd1; cmdData = 16'hBEEF;
        @(negedge clk);
        cmdValid = 1'b0; cmdOp = 3'd0;
        occ[i] = 1'b1; dat[i] = 16'hBEEF;
        check(fo[NS-1] == 1'b1, "R9 flag not yet changed", int'(fo[NS-1]), 1);
        repeat (NS) @(negedge clk);
        check(fo[NS-1] == 1'b0, "R9 system full after settle", int'(fo[NS-1]), 0);
      end else begin
        doWrite(16'h1000 + i);
      end
    end

    // R10 / R4: chain full
    doReadNext();
    doWrite(16'hDEAD);
    doReadEntry(0);
    doReadEntry(TOTAL - 1);

    // R7: scattered holes refilled lowest-first
    doDelete(13);
    doDelete(2);
    doDelete(6);
    doReadEntry(6);
    doReadNext();
    doWrite(16'h2222);
    doReadEntry(2);
    doReadNext();
    doWrite(16'h6666);
    doReadNext();
    doWrite(16'hD0D0);
    doReadEntry(13);

    // R7: idle cycles leave state alone
    repeat (5) @(negedge clk);
    doReadNext();

    // Random mix
    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 500; n++) begin
      int r = int'($urandom_range(0, 9));
      int a = int'($urandom_range(0, TOTAL - 1));
      if (r < 4)      doWrite(int'($urandom_range(0, 16'hFFFF)));
      else if (r < 6) doDelete(a);
      else if (r < 8) doReadNext();
      else            doReadEntry(a);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule